// File: doc/BRIEF.md
# PCIe Power-On Reset Release Sequencer

This block brings a PCIe root controller and its PHY out of power-on reset in a fixed order. A single start pulse launches the sequence. The block first holds the slot reset line low. It then releases the PHY and controller reset domains one group at a time by setting bits in a 32-bit reset-control word, with a timed wait in whole milliseconds after each group. Next it lets the slot reset line go high and releases the controller primary interface. Last, it loads the receiver phase mixer of each lane, one lane per cycle.

A parameter sets the number of clock cycles in one millisecond. A single shared down-counter measures every wait. While the sequence runs, and at any time before it has completed, a blocking output stays high. Configuration traffic must not reach the controller while that output is high. Completion is reported by a sticky done level.

Top module: `pcie_rst_seq`

## Requirements
- R1: After reset, `rst_ctl` is 0, `perst_n` is 0, every 2-bit lane field of `rx_mix` is 2'b11, `busy` and `done` are 0 and `cfg_block` is 1.
- R2: A start accepted at clock edge E0 sets `busy`, clears `done`, clears `rst_ctl` to 0, drives `perst_n` low and returns every lane field to 2'b11 at E0. At E0+1 it sets bits 16 and 19 of `rst_ctl` (mask 0x00090000).
- R3: Exactly LANE_MS*CYCLES_PER_MS cycles after the bit 16/19 update, bits 17 and 20 are set together in one update.
- R4: Exactly PLL_MS*CYCLES_PER_MS cycles after the bit 17/20 update, bit 18 is set.
- R5: Exactly CSB_MS*CYCLES_PER_MS cycles after the bit 18 update, `perst_n` goes high. By then bits 16 through 20 are all set.
- R6: One cycle after `perst_n` rises, bit 16 is written again for the primary interface release. `rst_ctl` stays 0x001F0000 to the end of the sequence.
- R7: During a sequence, no bit of `rst_ctl` that has been set is cleared.
- R8: Each lane field of `rx_mix` (bit 0 = mixer control bit 6, bit 1 = bit 7) becomes 2'b00 in lane order: lane k at 2+k cycles after `perst_n` rises. No field is cleared while `perst_n` is low.
- R9: `busy` falls and `done` rises on the edge that clears the last lane. `done` then holds until the next accepted start. `done` and `busy` are never both 1.
- R10: `cfg_block` is 1 whenever `done` is 0.
- R11: A start that arrives while `busy` is 1 has no effect on any output.
- R12: A start after completion runs the whole sequence again from the R2 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| perst_n | output | 1 | Slot reset line, low = asserted |
| rst_ctl | output | 32 | Reset-control word, a set bit releases a domain |
| rx_mix | output | 2*LANES | Per-lane mixer control pair, 2'b00 = loaded |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky completion flag |
| cfg_block | output | 1 | High while configuration access must be held off |

## Verification
A wrong state or a lost prescaler tick shows at the ports as a bit group in `rst_ctl`, or the `perst_n` edge, landing one or more cycles away from its millisecond boundary. The bench therefore compares every output in every cycle of each run against a schedule computed from the start edge, so any shift is reported in the cycle where it first appears. A start pulse that leaks through while busy shows as a cleared word or a reloaded wait within one cycle. A wrong lane index shows as a mixer field that clears out of order, or as `done` rising early.

// File: rtl/pcie_rst_pkg.sv
package pcie_rst_pkg;

   localparam int unsigned CTL_W = 32;

   // reset-control word groups; bit positions are decoded by the controller
   localparam logic [CTL_W-1:0] REL_PHY_LANE = 32'h0009_0000;
   localparam logic [CTL_W-1:0] REL_PHY_SB   = 32'h0002_0000;
   localparam logic [CTL_W-1:0] REL_MAIN     = 32'h0010_0000;
   localparam logic [CTL_W-1:0] REL_CTLR_SB  = 32'h0004_0000;
   localparam logic [CTL_W-1:0] REL_PRIMARY  = 32'h0001_0000;
   localparam logic [CTL_W-1:0] REL_ALL      = 32'h001F_0000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LANE,
      ST_W_LANE,
      ST_W_PLL,
      ST_W_CSB,
      ST_PRI,
      ST_MIX
   } seq_state_t;

endpackage

// File: rtl/rst_ms_timer.sv
module rst_ms_timer #(
   parameter int unsigned CYCLES_PER_MS = 25000,
   parameter int unsigned MS_W          = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [MS_W-1:0] load_ms,
   output logic            last
);
   localparam int unsigned PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYCLES_PER_MS - 1);

   logic [PRE_W-1:0] pre_q;
   logic [MS_W-1:0]  ms_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         ms_q  <= '0;
      end else if (load) begin
         pre_q <= PRE_TOP;
         ms_q  <= load_ms;
      end else if (ms_q != '0) begin
         if (pre_q == '0) begin
            pre_q <= PRE_TOP;
            ms_q  <= ms_q - 1'b1;
         end else begin
            pre_q <= pre_q - 1'b1;
         end
      end
   end

   // high during the final cycle of the loaded window
   assign last = (ms_q == MS_W'(1)) && (pre_q == '0);

   a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PRE_TOP);
   a_r3_window_ends: assert property (@(posedge clk) disable iff (!rst_n)
      last && !load |=> ms_q == '0);

endmodule

// File: rtl/rst_lane_mix.sv
module rst_lane_mix (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       fire,
   output logic [1:0] ctl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl <= 2'b11;
      else if (arm)  ctl <= 2'b11;
      else if (fire) ctl <= 2'b00;
   end

   a_r8_fire_loads: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !arm |=> ctl == 2'b00);
   a_r2_arm_restores: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> ctl == 2'b11);

endmodule

// File: rtl/pcie_rst_seq.sv
module pcie_rst_seq
   import pcie_rst_pkg::*;
#(
   parameter int unsigned CYCLES_PER_MS = 25000,
   parameter int unsigned LANES         = 2,
   parameter int unsigned LANE_MS       = 1,
   parameter int unsigned PLL_MS        = 80,
   parameter int unsigned CSB_MS        = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               perst_n,
   output logic [31:0]        rst_ctl,
   output logic [2*LANES-1:0] rx_mix,
   output logic               busy,
   output logic               done,
   output logic               cfg_block
);
   localparam int unsigned MAX_A  = (LANE_MS > PLL_MS) ? LANE_MS : PLL_MS;
   localparam int unsigned MAX_MS = (MAX_A > CSB_MS) ? MAX_A : CSB_MS;
   localparam int unsigned MS_W   = $clog2(MAX_MS + 1);
   localparam int unsigned LN_W   = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (CYCLES_PER_MS < 1) begin : g_bad_cpm
         $error("CYCLES_PER_MS must be at least 1");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (LANE_MS < 1 || PLL_MS < 1 || CSB_MS < 1) begin : g_bad_wait
         $error("every wait must be at least 1 ms");
      end
   endgenerate

   seq_state_t      state_q;
   logic [LN_W-1:0] lane_q;
   logic            tm_last;
   logic            tm_load;
   logic [MS_W-1:0] tm_ms;
   logic            accept;

   assign accept = start && (state_q == ST_IDLE);

   always_comb begin
      tm_load = 1'b0;
      tm_ms   = '0;
      unique case (state_q)
         ST_LANE: begin
            tm_load = 1'b1;
            tm_ms   = MS_W'(LANE_MS);
         end
         ST_W_LANE: begin
            tm_load = tm_last;
            tm_ms   = MS_W'(PLL_MS);
         end
         ST_W_PLL: begin
            tm_load = tm_last;
            tm_ms   = MS_W'(CSB_MS);
         end
         default: ;
      endcase
   end

   rst_ms_timer #(
      .CYCLES_PER_MS(CYCLES_PER_MS),
      .MS_W         (MS_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tm_load),
      .load_ms(tm_ms),
      .last   (tm_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rst_ctl <= '0;
         perst_n <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         lane_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               rst_ctl <= '0;
               perst_n <= 1'b0;
               busy    <= 1'b1;
               done    <= 1'b0;
               state_q <= ST_LANE;
            end
            ST_LANE: begin
               rst_ctl <= rst_ctl | REL_PHY_LANE;
               state_q <= ST_W_LANE;
            end
            ST_W_LANE: if (tm_last) begin
               rst_ctl <= rst_ctl | REL_PHY_SB | REL_MAIN;
               state_q <= ST_W_PLL;
            end
            ST_W_PLL: if (tm_last) begin
               rst_ctl <= rst_ctl | REL_CTLR_SB;
               state_q <= ST_W_CSB;
            end
            ST_W_CSB: if (tm_last) begin
               perst_n <= 1'b1;
               state_q <= ST_PRI;
            end
            ST_PRI: begin
               rst_ctl <= rst_ctl | REL_PRIMARY;
               lane_q  <= '0;
               state_q <= ST_MIX;
            end
            ST_MIX: begin
               if (lane_q == LN_W'(LANES - 1)) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  lane_q <= lane_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         rst_lane_mix u_mix (
            .clk  (clk),
            .rst_n(rst_n),
            .arm  (accept),
            .fire ((state_q == ST_MIX) && (lane_q == LN_W'(k))),
            .ctl  (rx_mix[2*k +: 2])
         );
      end
   endgenerate

   assign cfg_block = ~done;

   a_r7_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> (rst_ctl & $past(rst_ctl)) == $past(rst_ctl));
   a_r5_all_released: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perst_n) |-> (rst_ctl & REL_ALL) == REL_ALL);
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));
   a_r8_mix_after_perst: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mix != '1) |-> perst_n);
   a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && (state_q != ST_MIX) |=> busy && !done);

endmodule

// File: tb/pcie_rst_seq_test.sv
`timescale 1ns/1ps
module pcie_rst_seq_test;
   localparam int unsigned C   = 3;
   localparam int unsigned L   = 2;
   localparam int unsigned T2  = 1 + 1*C;
   localparam int unsigned T3  = T2 + 80*C;
   localparam int unsigned TP  = T3 + 20*C;
   localparam int unsigned TD  = TP + 1 + L;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           perst_n, busy, done, cfg_block;
   logic [31:0]    rst_ctl;
   logic [2*L-1:0] rx_mix;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pcie_rst_seq #(.CYCLES_PER_MS(C), .LANES(L)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .perst_n(perst_n),
      .rst_ctl(rst_ctl), .rx_mix(rx_mix), .busy(busy), .done(done),
      .cfg_block(cfg_block)
   );

   function automatic logic [31:0] exp_word(int t);
      logic [31:0] w = 32'h0;
      if (t >= 1)      w |= 32'h0009_0000;
      if (t >= T2)     w |= 32'h0012_0000;
      if (t >= T3)     w |= 32'h0004_0000;
      if (t >= TP + 1) w |= 32'h0001_0000;
      return w;
   endfunction

   function automatic logic [2*L-1:0] exp_mix(int t);
      logic [2*L-1:0] m = '1;
      for (int k = 0; k < L; k++)
         if (t >= TP + 2 + k) m[2*k +: 2] = 2'b00;
      return m;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic run_seq(string first_tag, bit noise);
      logic [31:0] prev = 32'h0;
      bit poked = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t <= TD + 2; t++) begin
         string wt;
         if (t == 0)       wt = first_tag;
         else if (poked)   wt = "R11";
         else if (t < T2)  wt = "R2";
         else if (t < T3)  wt = "R3";
         else if (t < TP)  wt = "R4";
         else              wt = "R6";
         chk(wt, "rst_ctl", rst_ctl, exp_word(t));
         chk("R5", "perst_n", 32'(perst_n), 32'(t >= TP));
         chk("R8", "rx_mix", 32'(rx_mix), 32'(exp_mix(t)));
         chk("R9", "busy", 32'(busy), 32'(t < TD));
         chk("R9", "done", 32'(done), 32'(t >= TD));
         chk("R10", "cfg_block", 32'(cfg_block), 32'(t < TD));
         if (t >= 1) chk("R7", "accumulate", rst_ctl & prev, prev);
         prev = rst_ctl;
         poked = noise && (t < TD) && ($urandom % 4 == 0);
         start = poked;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic idle_gap(int n);
      for (int i = 0; i < n; i++) begin
         chk("R9", "sticky done", 32'(done), 32'd1);
         chk("R9", "idle word", rst_ctl, 32'h001F_0000);
         chk("R10", "idle cfg_block", 32'(cfg_block), 32'd0);
         @(negedge clk);
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      chk("R1", "rst_ctl", rst_ctl, 32'h0);
      rst_n = 1'b1;
      repeat (2 + $urandom % 5) begin
         @(negedge clk);
         chk("R1", "rst_ctl", rst_ctl, 32'h0);
         chk("R1", "perst_n", 32'(perst_n), 32'd0);
         chk("R1", "rx_mix", 32'(rx_mix), 32'(4'hF));
         chk("R1", "busy", 32'(busy), 32'd0);
         chk("R1", "done", 32'(done), 32'd0);
         chk("R1", "cfg_block", 32'(cfg_block), 32'd1);
      end
      run_seq("R2", 1'b0);
      idle_gap(1 + $urandom % 6);
      for (int r = 0; r < 4; r++) begin
         run_seq("R12", 1'b1);
         idle_gap(1 + $urandom % 6);
      end
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule